// File: doc/BRIEF.md
# Multi-Channel Terminal Status and Command Register Bank

This block gives a host one command word and one status word for each channel of a serial bus terminal controller. Each 16-bit command write carries separate "set" and "clear" request bits for five held functions: interrupt enable, subsystem flag, timer-rate select, memory page select and automatic page-switch enable. A request bit at one executes its action. A request bit at zero does nothing. When both requests of one function are present in the same write, the clear takes priority.

The controller signals events as single-cycle pulses on two interrupt inputs per channel. These pulses are caught in sticky latches. The host can poll the latches in the status word at any time. They stay set until the host clears them with a command write. A channel raises a host interrupt line only while its interrupt enable is set. Neighbouring channels share a line in pairs.

A shared prescaler divides the system clock into two tick rates. Each channel passes one of them to its controller as a one-cycle timer strobe. The channel's page select and subsystem flag are driven out as plain levels.

Top module: `chanreg_top`

## Requirements
- R1: After reset every held function is zero, every interrupt latch is clear, the lower page is selected (pageSel low), and both host lines are low.
- R2: In a command write (wrEn[c] high), a one on a set bit sets the function and a one on a clear bit clears it. Set/clear pairs are: interrupt enable bits 2/3, subsystem flag 4/5, timer rate 8/9, page 12/13, page-switch enable 14/15. Bits written as zero leave their function unchanged, and channels whose wrEn is low are untouched.
- R3: When a write has both the set and the clear bit of one function at one, that function ends up cleared.
- R4: Page-switch enable becomes set only if monitorMode[c] is high during the write. A set request while monitorMode is low leaves it at zero.
- R5: The status word of channel c is statusFlat[16c+15:16c]. Bits 1:0 are the interrupt latches, 2 is interrupt enable, 4 the subsystem flag, 6 mirrors termActive[c], 7 mirrors ready[c], 8 the timer rate, 12 the page, and 14 page-switch enable. All other bits read zero.
- R6: A one-cycle high on irqPulse[2c+k] sets latch k of channel c (status bit k) from the next cycle on.
- R7: A latch stays set until a write to its channel has command bit k (bit 0 or 1) at one. If a new pulse arrives in the same cycle as the clear, the latch stays set.
- R8: hostIrq[0] is high when channel 0 or 1, and hostIrq[1] when channel 2 or 3, has interrupt enable set and at least one latch set. With interrupt enable at zero, the latches still read back in the status word.
- R9: timerTick[c] is a one-cycle strobe. It repeats every 32 clock cycles while the timer rate is zero and every 8192 cycles while it is one.
- R10: pageSel[c] equals status bit 12 and subsysFlag[c] equals status bit 4 of the same channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (8 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | NUM_CH | Per-channel command write strobe |
| wrData | input | 16 | Command word shared by all channels |
| monitorMode | input | NUM_CH | Controller of channel c runs as bus monitor |
| termActive | input | NUM_CH | Controller is processing a command |
| ready | input | NUM_CH | Controller has finished its initialization |
| irqPulse | input | 2*NUM_CH | Interrupt pulses, two per channel |
| statusFlat | output | 16*NUM_CH | Status words, channel c at bits 16c+15:16c |
| timerTick | output | NUM_CH | Selected timer strobe per channel |
| pageSel | output | NUM_CH | Memory page selected per channel |
| subsysFlag | output | NUM_CH | Subsystem flag to the controller |
| hostIrq | output | NUM_CH/2 | Host interrupt lines, one per channel pair |

## Verification
On every cycle, the checker verifies the parts of the behaviour that are local in time. It checks clear priority on interrupt enable and page-switch enable, that page-switch enable is refused outside monitor mode, and that each pulse lands in its latch. It also checks that latches hold until their clear bit is written, that the reserved status bits read zero, that each lit enabled channel forces its host line, and that the timer strobe lasts one cycle. Some properties only the bench scenarios can show: that the whole status word agrees with an independent model over long random command streams, that channels are isolated from each other, that a pulse coincident with a clear wins, and that tick spacing is exactly 32 or 8192 cycles.

// File: rtl/chanreg_pkg.sv
package chanreg_pkg;

  localparam int WORD_W     = 16;
  localparam int IRQ_PER_CH = 2;

  // command word bit positions
  localparam int CMD_IE_SET  = 2;
  localparam int CMD_IE_CLR  = 3;
  localparam int CMD_SF_SET  = 4;
  localparam int CMD_SF_CLR  = 5;
  localparam int CMD_TR_SET  = 8;
  localparam int CMD_TR_CLR  = 9;
  localparam int CMD_PG_SET  = 12;
  localparam int CMD_PG_CLR  = 13;
  localparam int CMD_PS_SET  = 14;
  localparam int CMD_PS_CLR  = 15;

  // status word bit positions
  localparam int STS_IE  = 2;
  localparam int STS_SF  = 4;
  localparam int STS_TA  = 6;
  localparam int STS_RDY = 7;
  localparam int STS_TR  = 8;
  localparam int STS_PG  = 12;
  localparam int STS_PS  = 14;

  // strobes from the command decoder to the datapath
  typedef struct packed {
    logic                  setIntEn;
    logic                  clrIntEn;
    logic                  setSub;
    logic                  clrSub;
    logic                  setTmr;
    logic                  clrTmr;
    logic                  setPage;
    logic                  clrPage;
    logic                  setPsw;
    logic                  clrPsw;
    logic [IRQ_PER_CH-1:0] clrIrq;
  } chanCmd_t;

endpackage

// File: rtl/chanreg_ctrl.sv
module chanreg_ctrl
  import chanreg_pkg::*;
(
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              monitorMode,
  output chanCmd_t          cmd
);

  // clear requests always pass; a set only passes without its clear
  always_comb begin
    cmd = '0;
    if (wrEn) begin
      cmd.clrIntEn = wrData[CMD_IE_CLR];
      cmd.setIntEn = wrData[CMD_IE_SET] & ~wrData[CMD_IE_CLR];
      cmd.clrSub   = wrData[CMD_SF_CLR];
      cmd.setSub   = wrData[CMD_SF_SET] & ~wrData[CMD_SF_CLR];
      cmd.clrTmr   = wrData[CMD_TR_CLR];
      cmd.setTmr   = wrData[CMD_TR_SET] & ~wrData[CMD_TR_CLR];
      cmd.clrPage  = wrData[CMD_PG_CLR];
      cmd.setPage  = wrData[CMD_PG_SET] & ~wrData[CMD_PG_CLR];
      cmd.clrPsw   = wrData[CMD_PS_CLR];
      cmd.setPsw   = wrData[CMD_PS_SET] & ~wrData[CMD_PS_CLR] & monitorMode;
      cmd.clrIrq   = wrData[IRQ_PER_CH-1:0];
    end
  end

endmodule

// File: rtl/chanreg_dp.sv
module chanreg_dp
  import chanreg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  chanCmd_t              cmd,
  input  logic [IRQ_PER_CH-1:0] irqPulse,
  input  logic                  termActive,
  input  logic                  ready,
  output logic [WORD_W-1:0]     statusWord,
  output logic                  intEn,
  output logic                  subsysFlag,
  output logic                  timerRes,
  output logic                  pageSel,
  output logic [IRQ_PER_CH-1:0] irqLatch
);

  logic pswEn;

  function automatic logic nextBit(input logic cur, input logic setReq, input logic clrReq);
    if (clrReq)      return 1'b0;
    else if (setReq) return 1'b1;
    else             return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intEn      <= 1'b0;
      subsysFlag <= 1'b0;
      timerRes   <= 1'b0;
      pageSel    <= 1'b0;
      pswEn      <= 1'b0;
    end else begin
      intEn      <= nextBit(intEn,      cmd.setIntEn, cmd.clrIntEn);
      subsysFlag <= nextBit(subsysFlag, cmd.setSub,   cmd.clrSub);
      timerRes   <= nextBit(timerRes,   cmd.setTmr,   cmd.clrTmr);
      pageSel    <= nextBit(pageSel,    cmd.setPage,  cmd.clrPage);
      pswEn      <= nextBit(pswEn,      cmd.setPsw,   cmd.clrPsw);
    end
  end

  // sticky interrupt latches; a fresh pulse outranks a clear
  for (genvar k = 0; k < IRQ_PER_CH; k++) begin : g_lat
    always_ff @(posedge clk) begin
      if (!rstN)            irqLatch[k] <= 1'b0;
      else if (irqPulse[k]) irqLatch[k] <= 1'b1;
      else if (cmd.clrIrq[k]) irqLatch[k] <= 1'b0;
    end
  end

  always_comb begin
    statusWord                   = '0;
    statusWord[IRQ_PER_CH-1:0]   = irqLatch;
    statusWord[STS_IE]           = intEn;
    statusWord[STS_SF]           = subsysFlag;
    statusWord[STS_TA]           = termActive;
    statusWord[STS_RDY]          = ready;
    statusWord[STS_TR]           = timerRes;
    statusWord[STS_PG]           = pageSel;
    statusWord[STS_PS]           = pswEn;
  end

endmodule

// File: rtl/chanreg_tick.sv
module chanreg_tick #(
  parameter int FAST_DIV = 32,
  parameter int SLOW_DIV = 256,
  localparam int FAST_W  = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1,
  localparam int SLOW_W  = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1
) (
  input  logic clk,
  input  logic rstN,
  output logic fastTick,
  output logic slowTick
);

  logic [FAST_W-1:0] fastCnt;
  logic [SLOW_W-1:0] slowCnt;
  logic fastWrap;
  logic slowWrap;

  assign fastWrap = (fastCnt == FAST_W'(FAST_DIV - 1));
  assign slowWrap = (slowCnt == SLOW_W'(SLOW_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fastCnt  <= '0;
      slowCnt  <= '0;
      fastTick <= 1'b0;
      slowTick <= 1'b0;
    end else begin
      fastCnt  <= fastWrap ? '0 : fastCnt + 1'b1;
      fastTick <= fastWrap;
      slowTick <= fastTick & slowWrap;
      if (fastTick) slowCnt <= slowWrap ? '0 : slowCnt + 1'b1;
    end
  end

endmodule

// File: rtl/chanreg_top.sv
module chanreg_top
  import chanreg_pkg::*;
#(
  parameter int NUM_CH       = 4,
  parameter int CH_PER_LINE  = 2,
  parameter int FAST_DIV     = 32,
  parameter int SLOW_DIV     = 256,
  localparam int NUM_LINES   = NUM_CH / CH_PER_LINE
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CH-1:0]            wrEn,
  input  logic [WORD_W-1:0]            wrData,
  input  logic [NUM_CH-1:0]            monitorMode,
  input  logic [NUM_CH-1:0]            termActive,
  input  logic [NUM_CH-1:0]            ready,
  input  logic [NUM_CH*IRQ_PER_CH-1:0] irqPulse,
  output logic [NUM_CH*WORD_W-1:0]     statusFlat,
  output logic [NUM_CH-1:0]            timerTick,
  output logic [NUM_CH-1:0]            pageSel,
  output logic [NUM_CH-1:0]            subsysFlag,
  output logic [NUM_LINES-1:0]         hostIrq
);

  logic fastTick;
  logic slowTick;
  logic [NUM_CH-1:0] chanIrq;

  chanreg_tick #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
    .clk      (clk),
    .rstN     (rstN),
    .fastTick (fastTick),
    .slowTick (slowTick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    chanCmd_t              cmd;
    logic                  intEn;
    logic                  timerRes;
    logic [IRQ_PER_CH-1:0] irqLatch;

    chanreg_ctrl u_ctrl (
      .wrEn        (wrEn[c]),
      .wrData      (wrData),
      .monitorMode (monitorMode[c]),
      .cmd         (cmd)
    );

    chanreg_dp u_dp (
      .clk        (clk),
      .rstN       (rstN),
      .cmd        (cmd),
      .irqPulse   (irqPulse[c*IRQ_PER_CH +: IRQ_PER_CH]),
      .termActive (termActive[c]),
      .ready      (ready[c]),
      .statusWord (statusFlat[c*WORD_W +: WORD_W]),
      .intEn      (intEn),
      .subsysFlag (subsysFlag[c]),
      .timerRes   (timerRes),
      .pageSel    (pageSel[c]),
      .irqLatch   (irqLatch)
    );

    assign timerTick[c] = timerRes ? slowTick : fastTick;
    assign chanIrq[c]   = intEn & (|irqLatch);
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign hostIrq[l] = |chanIrq[l*CH_PER_LINE +: CH_PER_LINE];
  end

endmodule

// File: rtl/chanreg_chk.sv
module chanreg_chk
  import chanreg_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int CH_PER_LINE = 2,
  localparam int NUM_LINES  = NUM_CH / CH_PER_LINE
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NUM_CH-1:0]            wrEn,
  input logic [WORD_W-1:0]            wrData,
  input logic [NUM_CH-1:0]            monitorMode,
  input logic [NUM_CH*IRQ_PER_CH-1:0] irqPulse,
  input logic [NUM_CH*WORD_W-1:0]     statusFlat,
  input logic [NUM_CH-1:0]            timerTick,
  input logic [NUM_LINES-1:0]         hostIrq
);

  localparam logic [WORD_W-1:0] USED_MASK =
    WORD_W'((1 << IRQ_PER_CH) - 1) | WORD_W'(1 << STS_IE) | WORD_W'(1 << STS_SF) |
    WORD_W'(1 << STS_TA) | WORD_W'(1 << STS_RDY) | WORD_W'(1 << STS_TR) |
    WORD_W'(1 << STS_PG) | WORD_W'(1 << STS_PS);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    logic [WORD_W-1:0] st;
    assign st = statusFlat[c*WORD_W +: WORD_W];

    // R3
    ie_clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn[c] && wrData[CMD_IE_SET] && wrData[CMD_IE_CLR]) |=> !st[STS_IE]);

    // R3
    psw_clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn[c] && wrData[CMD_PS_SET] && wrData[CMD_PS_CLR]) |=> !st[STS_PS]);

    // R4
    psw_needs_monitor_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!monitorMode[c] && !st[STS_PS]) |=> !st[STS_PS]);

    // R5
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (st & ~USED_MASK) == '0);

    // R9
    tick_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
      timerTick[c] |=> !timerTick[c]);

    for (genvar k = 0; k < IRQ_PER_CH; k++) begin : g_k
      // R6
      pulse_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
        irqPulse[c*IRQ_PER_CH + k] |=> st[k]);

      // R7
      latch_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
        (st[k] && !(wrEn[c] && wrData[k])) |=> st[k]);
    end

    // R8
    host_line_raised_chk: assert property (@(posedge clk) disable iff (!rstN)
      (st[STS_IE] && (|st[IRQ_PER_CH-1:0])) |-> hostIrq[c / CH_PER_LINE]);
  end

endmodule

bind chanreg_top chanreg_chk #(.NUM_CH(NUM_CH), .CH_PER_LINE(CH_PER_LINE)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .monitorMode (monitorMode),
  .irqPulse    (irqPulse),
  .statusFlat  (statusFlat),
  .timerTick   (timerTick),
  .hostIrq     (hostIrq)
);

// File: tb/sim_chanreg_top.sv
module sim_chanreg_top;

  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rstN;
  logic [NCH-1:0]   wrEn;
  logic [15:0]      wrData;
  logic [NCH-1:0]   monitorMode;
  logic [NCH-1:0]   termActive;
  logic [NCH-1:0]   ready;
  logic [2*NCH-1:0] irqPulse;
  logic [16*NCH-1:0] statusFlat;
  logic [NCH-1:0]   timerTick;
  logic [NCH-1:0]   pageSel;
  logic [NCH-1:0]   subsysFlag;
  logic [1:0]       hostIrq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  logic [NCH-1:0]   mIe, mSf, mTr, mPg, mPs;
  logic [2*NCH-1:0] mLat;

  always #2 clk = ~clk;

  chanreg_top u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .monitorMode(monitorMode), .termActive(termActive), .ready(ready),
    .irqPulse(irqPulse), .statusFlat(statusFlat), .timerTick(timerTick),
    .pageSel(pageSel), .subsysFlag(subsysFlag), .hostIrq(hostIrq)
  );

  function automatic logic upd(input logic cur, input logic s, input logic r);
    if (r) return 1'b0;
    if (s) return 1'b1;
    return cur;
  endfunction

  function automatic logic [15:0] expStatus(input int c);
    logic [15:0] s;
    s = '0;
    s[1:0] = mLat[2*c +: 2];
    s[2]   = mIe[c];
    s[4]   = mSf[c];
    s[6]   = termActive[c];
    s[7]   = ready[c];
    s[8]   = mTr[c];
    s[12]  = mPg[c];
    s[14]  = mPs[c];
    return s;
  endfunction

  function automatic logic [1:0] expHost();
    logic [1:0] h;
    h = '0;
    for (int c = 0; c < NCH; c++)
      if (mIe[c] && (|mLat[2*c +: 2])) h[c/2] = 1'b1;
    return h;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int c = 0; c < NCH; c++) begin
      check({tag, " R5 status"}, 32'(statusFlat[16*c +: 16]), 32'(expStatus(c)));
      check({tag, " R10 pageSel"}, 32'(pageSel[c]), 32'(mPg[c]));
      check({tag, " R10 subsysFlag"}, 32'(subsysFlag[c]), 32'(mSf[c]));
    end
    check({tag, " R8 hostIrq"}, 32'(hostIrq), 32'(expHost()));
  endtask

  task automatic step(input logic [NCH-1:0] we, input logic [15:0] d,
                      input logic [2*NCH-1:0] irq, input logic [NCH-1:0] mon);
    @(negedge clk);
    wrEn = we; wrData = d; irqPulse = irq; monitorMode = mon;
    @(posedge clk);
    #1;
    for (int c = 0; c < NCH; c++) begin
      if (we[c]) begin
        mIe[c] = upd(mIe[c], d[2], d[3]);
        mSf[c] = upd(mSf[c], d[4], d[5]);
        mTr[c] = upd(mTr[c], d[8], d[9]);
        mPg[c] = upd(mPg[c], d[12], d[13]);
        mPs[c] = upd(mPs[c], d[14] && mon[c], d[15]);
        mLat[2*c +: 2] = mLat[2*c +: 2] & ~d[1:0];
      end
    end
    mLat = mLat | irq;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, '0, '0);
  endtask

  // returns spacing in cycles between two consecutive ticks of channel c
  task automatic tickGap(input int c, output int gap);
    int cnt;
    gap = -1;
    @(negedge clk);
    wrEn = '0; irqPulse = '0;
    while (timerTick[c] !== 1'b1) @(negedge clk);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (timerTick[c] !== 1'b1 && cnt < 20000);
    gap = cnt;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int gap;
    void'($urandom(32'h5eed1553));
    rstN = 1'b0; wrEn = '0; wrData = '0; monitorMode = '0;
    termActive = '0; ready = '0; irqPulse = '0;
    mIe = '0; mSf = '0; mTr = '0; mPg = '0; mPs = '0; mLat = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 status", 32'(statusFlat), 32'h0);
    check("R1 pageSel", 32'(pageSel), 32'h0);
    check("R1 hostIrq", 32'(hostIrq), 32'h0);
    checkAll("R1");

    // R2 set, zero-bit writes, other channels untouched
    step(4'b0001, 16'h0004, '0, '0);
    check("R2 ie set", 32'(statusFlat[2]), 32'h1);
    checkAll("R2 set");
    step(4'b0001, 16'h0000, '0, '0);
    check("R2 zero write", 32'(statusFlat[2]), 32'h1);
    step(4'b0001, 16'h1110, '0, '0);
    checkAll("R2 multi set");
    check("R2 other ch", 32'(statusFlat[16 +: 16]), 32'h0);
    step(4'b0001, 16'h2228, '0, '0);
    checkAll("R2 clear");

    // R3 clear wins
    step(4'b1111, 16'hFFFC, '0, 4'b1111);
    check("R3 all pairs", 32'(statusFlat), 32'h0);
    checkAll("R3");

    // R4 monitor gating
    step(4'b0010, 16'h4000, '0, 4'b0000);
    check("R4 not monitor", 32'(statusFlat[16+14]), 32'h0);
    step(4'b0010, 16'h4000, '0, 4'b0010);
    check("R4 monitor", 32'(statusFlat[16+14]), 32'h1);
    checkAll("R4");

    // R6/R7 latching and clear
    step('0, '0, 8'b0000_0100, '0);
    check("R6 latched", 32'(statusFlat[16 +: 2]), 32'h1);
    check("R8 polled no ie", 32'(hostIrq), 32'h0);
    idle(3);
    check("R7 sticky", 32'(statusFlat[16 +: 2]), 32'h1);
    step(4'b0010, 16'h0002, '0, '0);
    check("R7 other clear", 32'(statusFlat[16 +: 2]), 32'h1);
    step(4'b0010, 16'h0001, 8'b0000_0100, '0);
    check("R7 pulse beats clear", 32'(statusFlat[16 +: 2]), 32'h1);
    step(4'b0010, 16'h0001, '0, '0);
    check("R7 cleared", 32'(statusFlat[16 +: 2]), 32'h0);

    // R8 pairing
    step('0, '0, 8'b0010_0000, '0);
    check("R8 gated", 32'(hostIrq), 32'h0);
    step(4'b0100, 16'h0004, '0, '0);
    check("R8 line two", 32'(hostIrq), 32'h2);
    checkAll("R8");

    // R10 outputs
    step(4'b1000, 16'h1010, '0, '0);
    check("R10 page out", 32'(pageSel), 32'h8);
    check("R10 subsys out", 32'(subsysFlag), 32'h8);

    // random mix against model
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      d = 16'($urandom) & 16'($urandom | $urandom);
      termActive = 4'($urandom);
      ready      = 4'($urandom);
      step(4'($urandom), d, 8'($urandom) & 8'($urandom), 4'($urandom));
      checkAll("rand");
    end

    // R9 timer rates
    step(4'b1111, 16'h0200, '0, '0);
    tickGap(0, gap);
    check("R9 fast gap", 32'(gap), 32'd32);
    step(4'b0001, 16'h0100, '0, '0);
    tickGap(0, gap);
    check("R9 slow gap", 32'(gap), 32'd8192);
    tickGap(1, gap);
    check("R9 other ch fast", 32'(gap), 32'd32);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule